// File: doc/BRIEF.md
# Line Buffer Configuration Selector

This block chooses how the vertical scaler's line memory is split before a frame starts. From the source viewport widths, the output rectangle width, the stored pixel depth, the vertical tap counts and scale ratios for luma and chroma, the alpha enable and the 4:2:0 flag, it works out how many whole lines each memory arrangement can hold. It then settles on the first arrangement that holds enough lines for the vertical filter.

A request is a one-cycle `start` while `busy` is low. The block captures every input on that edge. It then runs one shared restoring divider over the line costs and the partition counts, one configuration after another. When it finishes it raises `done` for exactly one cycle and holds the chosen configuration code, the luma and chroma partition counts and an error flag until the next result. The state machine has five states. IDLE waits for a request. LOAD launches one division. WAIT collects the quotient. JUDGE applies the fit rule to the current configuration. FIN presents the result. The transitions are:
- IDLE→LOAD on a normal request.
- IDLE→FIN on a forced request.
- LOAD→WAIT always.
- WAIT→LOAD while divisions remain.
- WAIT→JUDGE after the last partition division.
- JUDGE→LOAD to try the next configuration.
- JUDGE→FIN when a configuration fits or the fallback has been judged.
- FIN→IDLE always.

Top module: `lbsel_top`

## Requirements
- R1: The luma line width is min(luma viewport width, output width). The chroma line width is min(chroma viewport width, output width). A resulting width of 0 is used as 1.
- R2: Depth code 0 means 10 bits per component, 1 means 8, 2 means 6 and 3 means 12. The luma and chroma line costs are ceil(width·bpc/72) words. The alpha line cost is ceil(luma width/6) words.
- R3: The memory words per configuration code are as follows. Code 1: luma 816, chroma 816, alpha 984. Code 2: 1088, 1088, 1312. Code 3: 4448, 1904, 2752. Code 0: 2752 for all three.
- R4: Each partition count is the memory words divided by the line cost, rounded down. With alpha enabled, the luma count drops to the alpha count if that is smaller. Both reported counts are then capped at 64.
- R5: With c = ceil(vertical ratio), a lane fits when taps + c ≤ partitions + 2 for c > 2, and when taps ≤ partitions otherwise. A configuration fits only when both luma and chroma fit.
- R6: The order of trial is code 1, then code 2, then code 3 (only when the 4:2:0 flag is set), then code 0. The first fitting code is reported. Code 0 is reported if nothing fits.
- R7: `error` is 1 when code 0 was reached and does not fit, and 0 otherwise.
- R8: A request with `force_max` set reports code 3 when 4:2:0 and code 0 otherwise, with zero partition counts and no error. `done` follows one cycle after the request.
- R9: `done` is high for one cycle per accepted request. `start` is ignored while `busy` is high, including the cycle in which `done` is high. Results hold until the next `done`.
- R10: After reset, `busy`, `done`, `cfg`, both counts and `error` are 0. `max_parts` is always 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when idle |
| force_max | input | 1 | Skip evaluation and pick the largest arrangement |
| is_420 | input | 1 | Source is 4:2:0 |
| alpha_en | input | 1 | Alpha plane is stored |
| depth_code | input | 2 | Stored pixel depth code |
| vp_width | input | 14 | Luma viewport width |
| vp_width_c | input | 14 | Chroma viewport width |
| out_width | input | 14 | Output rectangle width |
| vtaps_y | input | 4 | Luma vertical taps |
| vtaps_c | input | 4 | Chroma vertical taps |
| vratio_y | input | 12 | Luma vertical ratio, 4.8 unsigned fixed point |
| vratio_c | input | 12 | Chroma vertical ratio, 4.8 unsigned fixed point |
| busy | output | 1 | Request in progress |
| done | output | 1 | Result valid pulse |
| cfg | output | 2 | Chosen configuration code |
| parts_y | output | 7 | Luma partition count |
| parts_c | output | 7 | Chroma partition count |
| error | output | 1 | Fallback did not fit |
| max_parts | output | 7 | Fixed maximum partitions value |

## Verification
Two events can fall in the same cycle: a new `start` and the `done` pulse of the previous request. Another can also overlap: a request arriving while the divider is mid-run. The bench raises `start` in exactly the cycle where `done` is seen. It then checks that `busy` is low one cycle later, so no second run was launched. It also drives a request with different operands in the middle of a run and checks that the reported result still matches the first operands.

// File: rtl/lbsel_pkg.sv
package lbsel_pkg;

    localparam int MEM_W = 13;

    typedef enum logic [1:0] {
        CFG0 = 2'd0,
        CFG1 = 2'd1,
        CFG2 = 2'd2,
        CFG3 = 2'd3
    } cfg_e;

    typedef enum logic [1:0] {
        LANE_Y = 2'd0,
        LANE_C = 2'd1,
        LANE_A = 2'd2
    } lane_e;

    function automatic logic [MEM_W-1:0] mem_words(input cfg_e c, input lane_e l);
        logic [MEM_W-1:0] w;
        unique case (c)
            CFG1: w = (l == LANE_A) ? 13'd984  : 13'd816;
            CFG2: w = (l == LANE_A) ? 13'd1312 : 13'd1088;
            CFG3: w = (l == LANE_Y) ? 13'd4448 : ((l == LANE_C) ? 13'd1904 : 13'd2752);
            default: w = 13'd2752;
        endcase
        return w;
    endfunction

    function automatic logic [3:0] depth_bpc(input logic [1:0] code);
        logic [3:0] b;
        unique case (code)
            2'd0: b = 4'd10;
            2'd1: b = 4'd8;
            2'd2: b = 4'd6;
            default: b = 4'd12;
        endcase
        return b;
    endfunction

    function automatic logic rule_ok(input logic [15:0] taps, input logic [15:0] rc,
                                     input logic [15:0] parts);
        if (rc > 16'd2)
            return (taps + rc) <= (parts + 16'd2);
        else
            return taps <= parts;
    endfunction

endpackage

// File: rtl/lbsel_divider.sv
module lbsel_divider #(
    parameter int DW = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [DW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [DW-1:0] quo
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] rem_q, quo_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic [DW:0]   shifted, diff;
    logic          ge;

    always_comb begin
        shifted = {rem_q, quo_q[DW-1]};
        diff    = shifted - {1'b0, den};
        ge      = ~diff[DW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin   <= 1'b0;
        end else if (go) begin
            rem_q <= '0;
            quo_q <= num;
            cnt_q <= CW'(DW);
            run_q <= 1'b1;
            fin   <= 1'b0;
        end else if (run_q) begin
            rem_q <= ge ? diff[DW-1:0] : shifted[DW-1:0];
            quo_q <= {quo_q[DW-2:0], ge};
            cnt_q <= cnt_q - 1'b1;
            fin   <= (cnt_q == CW'(1));
            if (cnt_q == CW'(1))
                run_q <= 1'b0;
        end else begin
            fin <= 1'b0;
        end
    end

    assign quo = quo_q;
endmodule

// File: rtl/lbsel_judge.sv
module lbsel_judge
    import lbsel_pkg::*;
#(
    parameter int TAP_W = 4,
    parameter int RI_W  = 4,
    parameter int RF_W  = 8,
    parameter int CNT_W = 7,
    parameter int CAP   = 64
) (
    input  logic [MEM_W-1:0]     raw_y,
    input  logic [MEM_W-1:0]     raw_c,
    input  logic [MEM_W-1:0]     raw_a,
    input  logic                 alpha_en,
    input  logic [TAP_W-1:0]     taps_y,
    input  logic [TAP_W-1:0]     taps_c,
    input  logic [RI_W+RF_W-1:0] ratio_y,
    input  logic [RI_W+RF_W-1:0] ratio_c,
    output logic [CNT_W-1:0]     cnt_y,
    output logic [CNT_W-1:0]     cnt_c,
    output logic                 fits
);
    logic [MEM_W-1:0] adj_y;
    logic [RI_W:0]    ceil_y, ceil_c;

    always_comb begin
        adj_y  = (alpha_en && (raw_a < raw_y)) ? raw_a : raw_y;
        cnt_y  = (adj_y > MEM_W'(CAP)) ? CNT_W'(CAP) : adj_y[CNT_W-1:0];
        cnt_c  = (raw_c > MEM_W'(CAP)) ? CNT_W'(CAP) : raw_c[CNT_W-1:0];
        ceil_y = {1'b0, ratio_y[RI_W+RF_W-1:RF_W]} + (RI_W+1)'(|ratio_y[RF_W-1:0]);
        ceil_c = {1'b0, ratio_c[RI_W+RF_W-1:RF_W]} + (RI_W+1)'(|ratio_c[RF_W-1:0]);
        fits   = rule_ok(16'(taps_y), 16'(ceil_y), 16'(cnt_y)) &&
                 rule_ok(16'(taps_c), 16'(ceil_c), 16'(cnt_c));
    end
endmodule

// File: rtl/lbsel_top.sv
module lbsel_top
    import lbsel_pkg::*;
#(
    parameter int WID_W     = 14,
    parameter int TAP_W     = 4,
    parameter int RI_W      = 4,
    parameter int RF_W      = 8,
    parameter int CNT_W     = 7,
    parameter int PART_CAP  = 64,
    parameter int MAX_PARTS = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 force_max,
    input  logic                 is_420,
    input  logic                 alpha_en,
    input  logic [1:0]           depth_code,
    input  logic [WID_W-1:0]     vp_width,
    input  logic [WID_W-1:0]     vp_width_c,
    input  logic [WID_W-1:0]     out_width,
    input  logic [TAP_W-1:0]     vtaps_y,
    input  logic [TAP_W-1:0]     vtaps_c,
    input  logic [RI_W+RF_W-1:0] vratio_y,
    input  logic [RI_W+RF_W-1:0] vratio_c,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           cfg,
    output logic [CNT_W-1:0]     parts_y,
    output logic [CNT_W-1:0]     parts_c,
    output logic                 error,
    output logic [CNT_W-1:0]     max_parts
);
    localparam int DW = WID_W + 5;

    typedef enum logic [2:0] {S_IDLE, S_LOAD, S_WAIT, S_JUDGE, S_FIN} st_e;
    st_e state, nxt;

    logic [WID_W-1:0]     line_y, line_c, eff_y, eff_c;
    logic [3:0]           bpc_q;
    logic                 alpha_q, is420_q;
    logic [TAP_W-1:0]     taps_y_q, taps_c_q;
    logic [RI_W+RF_W-1:0] ratio_y_q, ratio_c_q;
    logic [2:0]           op;
    cfg_e                 cfg_cur, cfg_next;
    logic [DW-1:0]        cost_y, cost_c, cost_a;
    logic [MEM_W-1:0]     raw_y, raw_c, raw_a;
    logic [DW-1:0]        div_num, div_den, div_quo;
    logic                 div_go, div_fin;
    logic [CNT_W-1:0]     j_y, j_c;
    logic                 j_fits;
    logic [1:0]           cfg_q;
    logic [CNT_W-1:0]     py_q, pc_q;
    logic                 err_q;

    // effective widths from the ports, captured on request
    always_comb begin
        eff_y = (vp_width   < out_width) ? vp_width   : out_width;
        eff_c = (vp_width_c < out_width) ? vp_width_c : out_width;
        if (eff_y == '0) eff_y = WID_W'(1);
        if (eff_c == '0) eff_c = WID_W'(1);
    end

    // divider operand select by operation index
    always_comb begin
        unique case (op)
            3'd0: begin div_num = DW'(line_y) * DW'(bpc_q) + DW'(71); div_den = DW'(72); end
            3'd1: begin div_num = DW'(line_c) * DW'(bpc_q) + DW'(71); div_den = DW'(72); end
            3'd2: begin div_num = DW'(line_y) + DW'(5);               div_den = DW'(6);  end
            3'd3: begin div_num = DW'(mem_words(cfg_cur, LANE_Y));    div_den = cost_y;  end
            3'd4: begin div_num = DW'(mem_words(cfg_cur, LANE_C));    div_den = cost_c;  end
            default: begin div_num = DW'(mem_words(cfg_cur, LANE_A)); div_den = cost_a;  end
        endcase
    end

    always_comb begin
        unique case (cfg_cur)
            CFG1:    cfg_next = CFG2;
            CFG2:    cfg_next = is420_q ? CFG3 : CFG0;
            default: cfg_next = CFG0;
        endcase
    end

    lbsel_divider #(.DW(DW)) u_div (
        .clk(clk), .rst_n(rst_n), .go(div_go),
        .num(div_num), .den(div_den), .fin(div_fin), .quo(div_quo)
    );

    lbsel_judge #(
        .TAP_W(TAP_W), .RI_W(RI_W), .RF_W(RF_W), .CNT_W(CNT_W), .CAP(PART_CAP)
    ) u_judge (
        .raw_y(raw_y), .raw_c(raw_c), .raw_a(raw_a), .alpha_en(alpha_q),
        .taps_y(taps_y_q), .taps_c(taps_c_q),
        .ratio_y(ratio_y_q), .ratio_c(ratio_c_q),
        .cnt_y(j_y), .cnt_c(j_c), .fits(j_fits)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = force_max ? S_FIN : S_LOAD;
            S_LOAD:  nxt = S_WAIT;
            S_WAIT:  if (div_fin) nxt = (op == 3'd5) ? S_JUDGE : S_LOAD;
            S_JUDGE: nxt = (j_fits || cfg_cur == CFG0) ? S_FIN : S_LOAD;
            S_FIN:   nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FIN);
        div_go    = (state == S_LOAD);
        cfg       = cfg_q;
        parts_y   = py_q;
        parts_c   = pc_q;
        error     = err_q;
        max_parts = CNT_W'(MAX_PARTS);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_y <= '0; line_c <= '0; bpc_q <= '0;
            alpha_q <= 1'b0; is420_q <= 1'b0;
            taps_y_q <= '0; taps_c_q <= '0; ratio_y_q <= '0; ratio_c_q <= '0;
            op <= '0; cfg_cur <= CFG1;
            cost_y <= '0; cost_c <= '0; cost_a <= '0;
            raw_y <= '0; raw_c <= '0; raw_a <= '0;
            cfg_q <= '0; py_q <= '0; pc_q <= '0; err_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    line_y    <= eff_y;
                    line_c    <= eff_c;
                    bpc_q     <= depth_bpc(depth_code);
                    alpha_q   <= alpha_en;
                    is420_q   <= is_420;
                    taps_y_q  <= vtaps_y;
                    taps_c_q  <= vtaps_c;
                    ratio_y_q <= vratio_y;
                    ratio_c_q <= vratio_c;
                    op        <= '0;
                    cfg_cur   <= CFG1;
                    if (force_max) begin
                        cfg_q <= is_420 ? 2'd3 : 2'd0;
                        py_q  <= '0;
                        pc_q  <= '0;
                        err_q <= 1'b0;
                    end
                end
                S_WAIT: if (div_fin) begin
                    unique case (op)
                        3'd0: cost_y <= div_quo;
                        3'd1: cost_c <= div_quo;
                        3'd2: cost_a <= div_quo;
                        3'd3: raw_y  <= div_quo[MEM_W-1:0];
                        3'd4: raw_c  <= div_quo[MEM_W-1:0];
                        default: raw_a <= div_quo[MEM_W-1:0];
                    endcase
                    if (op != 3'd5) op <= op + 3'd1;
                end
                S_JUDGE: begin
                    if (j_fits || cfg_cur == CFG0) begin
                        cfg_q <= cfg_cur;
                        py_q  <= j_y;
                        pc_q  <= j_c;
                        err_q <= ~j_fits;
                    end else begin
                        cfg_cur <= cfg_next;
                        op      <= 3'd3;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lbsel_checker.sv
module lbsel_checker #(
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             force_max,
    input logic             is_420,
    input logic             busy,
    input logic             done,
    input logic [1:0]       cfg,
    input logic [CNT_W-1:0] parts_y,
    input logic [CNT_W-1:0] parts_c,
    input logic             error
);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy && !done) |=> busy);

    assert_count_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (parts_y <= CNT_W'(64) && parts_c <= CNT_W'(64)));

    assert_error_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (cfg == 2'd0));

    assert_force_pick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && force_max) |=>
            (done && !error && cfg == ($past(is_420) ? 2'd3 : 2'd0)));
endmodule

bind lbsel_top lbsel_checker #(.CNT_W(CNT_W)) u_lbsel_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .force_max(force_max), .is_420(is_420),
    .busy(busy), .done(done), .cfg(cfg), .parts_y(parts_y), .parts_c(parts_c),
    .error(error)
);

// File: tb/lbsel_top_test.sv
`timescale 1ns/1ps
module lbsel_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, force_max = 1'b0, is_420 = 1'b0, alpha_en = 1'b0;
    logic [1:0]  depth_code = '0;
    logic [13:0] vp_width = '0, vp_width_c = '0, out_width = '0;
    logic [3:0]  vtaps_y = '0, vtaps_c = '0;
    logic [11:0] vratio_y = '0, vratio_c = '0;
    logic        busy, done, error;
    logic [1:0]  cfg;
    logic [6:0]  parts_y, parts_c, max_parts;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    lbsel_top uut (
        .clk(clk), .rst_n(rst_n), .start(start), .force_max(force_max), .is_420(is_420),
        .alpha_en(alpha_en), .depth_code(depth_code), .vp_width(vp_width),
        .vp_width_c(vp_width_c), .out_width(out_width), .vtaps_y(vtaps_y),
        .vtaps_c(vtaps_c), .vratio_y(vratio_y), .vratio_c(vratio_c),
        .busy(busy), .done(done), .cfg(cfg), .parts_y(parts_y), .parts_c(parts_c),
        .error(error), .max_parts(max_parts)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rfits(int taps, int rc, int p);
        if (rc > 2) return (taps + rc <= p + 2) ? 1 : 0;
        return (taps <= p) ? 1 : 0;
    endfunction

    function automatic int memw(int c, int lane);
        case (c)
            1: return (lane == 2) ? 984 : 816;
            2: return (lane == 2) ? 1312 : 1088;
            3: return (lane == 0) ? 4448 : ((lane == 1) ? 1904 : 2752);
            default: return 2752;
        endcase
    endfunction

    task automatic model(output int e_cfg, output int e_py, output int e_pc, output int e_err);
        int ly, lc, bpc, cy, cc, ca, py, pc, pa, ry, rc, c, ok;
        int order[4];
        if (force_max) begin
            e_cfg = is_420 ? 3 : 0; e_py = 0; e_pc = 0; e_err = 0;
            return;
        end
        ly = (vp_width < out_width) ? vp_width : out_width;
        lc = (vp_width_c < out_width) ? vp_width_c : out_width;
        if (ly == 0) ly = 1;
        if (lc == 0) lc = 1;
        bpc = (depth_code == 0) ? 10 : (depth_code == 1) ? 8 : (depth_code == 2) ? 6 : 12;
        cy = (ly * bpc + 71) / 72;
        cc = (lc * bpc + 71) / 72;
        ca = (ly + 5) / 6;
        ry = int'(vratio_y[11:8]) + ((vratio_y[7:0] != 0) ? 1 : 0);
        rc = int'(vratio_c[11:8]) + ((vratio_c[7:0] != 0) ? 1 : 0);
        order[0] = 1; order[1] = 2; order[2] = is_420 ? 3 : 0; order[3] = 0;
        for (int i = 0; i < 4; i++) begin
            c  = order[i];
            py = memw(c, 0) / cy;
            pc = memw(c, 1) / cc;
            pa = memw(c, 2) / ca;
            if (alpha_en && pa < py) py = pa;
            if (py > 64) py = 64;
            if (pc > 64) pc = 64;
            ok = rfits(vtaps_y, ry, py) & rfits(vtaps_c, rc, pc);
            if (ok == 1 || c == 0) begin
                e_cfg = c; e_py = py; e_pc = pc; e_err = (ok == 1) ? 0 : 1;
                return;
            end
        end
    endtask

    task automatic run_and_check(input string tag);
        int e_cfg, e_py, e_pc, e_err;
        model(e_cfg, e_py, e_pc, e_err);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        chk({tag, " R6 cfg"}, cfg, e_cfg);
        chk({tag, " R3/R4 parts_y"}, parts_y, e_py);
        chk({tag, " R4 parts_c"}, parts_c, e_pc);
        chk({tag, " R5/R7 error"}, error, e_err);
    endtask

    task automatic set_vec(input int wy, input int wc, input int wo, input int dc,
                           input int ty, input int tc, input int ry, input int rc,
                           input bit al, input bit f420, input bit frc);
        vp_width = 14'(wy); vp_width_c = 14'(wc); out_width = 14'(wo);
        depth_code = 2'(dc); vtaps_y = 4'(ty); vtaps_c = 4'(tc);
        vratio_y = 12'(ry); vratio_c = 12'(rc);
        alpha_en = al; is_420 = f420; force_max = frc;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5eed_1b0f);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 busy", busy, 0);
        chk("R10 done", done, 0);
        chk("R10 cfg", cfg, 0);
        chk("R10 parts_y", parts_y, 0);
        chk("R10 error", error, 0);
        chk("R10 max_parts", max_parts, 63);

        // R1 zero width treated as one; narrow output limits width
        set_vec(0, 0, 1920, 1, 4, 4, 256, 256, 0, 0, 0);
        run_and_check("R1 zero");
        set_vec(3840, 1920, 1280, 0, 6, 6, 512, 512, 1, 1, 0);
        run_and_check("R1 min");
        // R2 each depth code
        for (int d = 0; d < 4; d++) begin
            set_vec(4096, 2048, 4096, d, 6, 4, 600, 600, 0, 1, 0);
            run_and_check("R2 depth");
        end
        // R7 nothing fits
        set_vec(16383, 16383, 16383, 3, 15, 15, 2048, 2048, 0, 0, 0);
        run_and_check("R7 nofit");
        // R8 forced choice
        set_vec(100, 100, 100, 0, 2, 2, 256, 256, 0, 1, 1);
        run_and_check("R8 force420");
        set_vec(100, 100, 100, 0, 2, 2, 256, 256, 0, 0, 1);
        run_and_check("R8 force444");
        // R6 config 3 reachable only with 4:2:0
        set_vec(7000, 3500, 7000, 3, 8, 4, 768, 384, 0, 1, 0);
        run_and_check("R6 t420");
        set_vec(7000, 3500, 7000, 3, 8, 4, 768, 384, 0, 0, 0);
        run_and_check("R6 t444");

        // R9 start while busy is ignored
        begin
            int e_cfg, e_py, e_pc, e_err;
            set_vec(5000, 2500, 5000, 0, 8, 8, 640, 640, 1, 1, 0);
            model(e_cfg, e_py, e_pc, e_err);
            @(negedge clk); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (5) @(negedge clk);
            set_vec(10, 10, 10, 1, 1, 1, 256, 256, 0, 0, 1);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            while (!done) @(negedge clk);
            chk("R9 busy-start cfg", cfg, e_cfg);
            chk("R9 busy-start parts_y", parts_y, e_py);
            // start in the done cycle
            start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk("R9 start-at-done busy", busy, 0);
            chk("R9 start-at-done done", done, 0);
        end

        // random
        for (int n = 0; n < 150; n++) begin
            int wy, wc, wo;
            wy = ($urandom % 2) ? ($urandom % 64) : ($urandom % 16384);
            wc = ($urandom % 2) ? (wy / 2) : ($urandom % 16384);
            wo = ($urandom % 16384);
            set_vec(wy, wc, wo, $urandom % 4, 1 + $urandom % 15, 1 + $urandom % 15,
                    $urandom % 2048, $urandom % 2048, 1'($urandom % 2),
                    1'($urandom % 2), ($urandom % 10) == 0);
            run_and_check("rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule